// File: doc/BRIEF.md
# Octant-Folded Gauge Drive Decoder

This block sits between the code latches of a triple air-core gauge driver and its coil output amplifiers. It takes a 10-bit pointer angle for one major gauge and a code word for each minor gauge. It produces registered source selections for every amplifier, plus the digital codes for the DAC levels. Analog levels and amplifier behaviour are handled elsewhere. This block only decides, per amplifier, whether to drive the high rail, the low rail or the DAC level, and which DAC code applies.

The major gauge uses two coils, sine and cosine, and each coil has a positive end and a negative end. The top three code bits give the octant of the pointer angle. In every octant one coil is driven rail to rail at full strength. The other coil has one end on a rail and the other end on the DAC, so its voltage tracks the folded 7-bit code. In odd octants the low seven bits are inverted, so one 128-level DAC covers the whole circle. A minor gauge uses one coil with two amplifier sides. Each side is either at the high rail or at the DAC level. Bit 7 of the minor word swaps the two sides and also folds the DAC code. The two bits above bit 7 must be zero for the minor output to be enabled.

Each channel has its own load strobe. The outputs of a channel take the decoded value on the clock edge where its strobe is high, and otherwise they hold.

Top module: `gauge_drive_decoder`

## Requirements
- R1: While reset is low and after it is released with no load, every major selection is low rail (code 0), the major DAC code is 0, both minor side flags are 0, every minor DAC code is 0 and every minor enable is 0.
- R2: The outputs of a channel change only at a clock edge where that channel's load strobe is high, and then they reflect the word presented at that edge. With the strobe low, a changing input word has no effect.
- R3: The major DAC code equals bits 6..0 of the word, all inverted when bit 7 is 1.
- R4: Selections are encoded as low rail = 0, high rail = 1, DAC = 2. The sine coil uses the DAC in octants 0, 3, 4 and 7 (octant = bits 9..7). The cosine coil uses it in octants 1, 2, 5 and 6. The other coil is driven rail to rail, and at most one amplifier selects the DAC.
- R5: The sine coil is positive (positive end high rail or DAC, negative end low rail) in octants 0..3 and reversed in octants 4..7. The cosine coil is positive in octants 0, 1, 6 and 7 and reversed in octants 2..5.
- R6: Code 0 gives sine on the DAC at code 0 with cosine at full positive. Code 256 gives sine at full positive with cosine on the DAC at code 0. Code 512 gives sine on the DAC at code 0 with cosine at full negative. Code 768 gives sine at full negative with cosine on the DAC at code 0.
- R7: The minor DAC code equals bits 6..0 of the minor word, inverted when bit 7 is 1.
- R8: A minor side flag of 1 means DAC and 0 means high rail. When bit 7 is 0, side A is high rail and side B is DAC. When bit 7 is 1 they swap, and the two sides never both select the DAC.
- R9: A minor enable is 1 exactly when bits 9..8 of its loaded word are both 0.
- R10: A load on one channel leaves the outputs of every other channel unchanged, and loads on several channels in the same cycle each take effect.
- R11: Across consecutive codes within one major octant, the DAC code rises by one in even octants and falls by one in odd octants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| maj_load | input | 1 | Major channel load strobe |
| maj_word | input | 10 | Major angle code |
| min_load | input | N_MINOR | Per-minor-channel load strobes |
| min_word | input | N_MINOR*10 | Minor code words, channel g at bits g*10 upward |
| sin_p_sel | output | 2 | Sine coil positive end source |
| sin_n_sel | output | 2 | Sine coil negative end source |
| cos_p_sel | output | 2 | Cosine coil positive end source |
| cos_n_sel | output | 2 | Cosine coil negative end source |
| maj_dac | output | 7 | Major DAC code |
| min_a_dac | output | N_MINOR | Minor side A uses DAC (1) or high rail (0) |
| min_b_dac | output | N_MINOR | Minor side B uses DAC (1) or high rail (0) |
| min_dac | output | N_MINOR*7 | Minor DAC codes, channel g at bits g*7 upward |
| min_en | output | N_MINOR | Minor output enable |

## Verification
A major angle load and a minor code load can land on the same clock edge. Each channel's register must then take its own word, and a channel whose strobe is low must keep its earlier value. The bench provokes this by asserting the major strobe and one minor strobe together, while the other minor channel's word changes with its strobe low. The scoreboard compares a full expected snapshot of every output one edge later. The flip of minor side A and side B across the crossover codes is also checked in that same style.

// File: rtl/gdd_pkg.sv
`timescale 1ns/1ps
package gdd_pkg;

   typedef enum logic [1:0] {
      DRV_LO  = 2'd0,
      DRV_HI  = 2'd1,
      DRV_DAC = 2'd2
   } drv_sel_e;

   typedef struct packed {
      drv_sel_e pos;
      drv_sel_e neg;
   } coil_drv_t;

   // Route one coil: on the DAC, one end follows the DAC and the other sits
   // on the low rail; otherwise the coil is driven rail to rail.
   function automatic coil_drv_t coil_route(input logic on_dac, input logic negative);
      coil_drv_t r;
      if (on_dac) begin
         r.pos = negative ? DRV_LO  : DRV_DAC;
         r.neg = negative ? DRV_DAC : DRV_LO;
      end else begin
         r.pos = negative ? DRV_LO  : DRV_HI;
         r.neg = negative ? DRV_HI  : DRV_LO;
      end
      return r;
   endfunction

endpackage

// File: rtl/gdd_major_dec.sv
`timescale 1ns/1ps
module gdd_major_dec
   import gdd_pkg::*;
#(
   parameter int DAC_W  = 7,
   parameter int CODE_W = 10
) (
   input  logic [CODE_W-1:0] code,
   output coil_drv_t         sin_drv,
   output coil_drv_t         cos_drv,
   output logic [DAC_W-1:0]  dac
);
   localparam int OCT_W = CODE_W - DAC_W;

   logic [OCT_W-1:0] octant;
   logic             sin_on_dac;
   logic             sin_neg;
   logic             cos_neg;

   assign octant = code[CODE_W-1:DAC_W];

   // odd octants run the DAC code backwards
   assign dac = code[DAC_W-1:0] ^ {DAC_W{octant[0]}};

   // sine is small near 0 and 180 degrees
   assign sin_on_dac = ~(octant[1] ^ octant[0]);
   assign sin_neg    = octant[2];
   assign cos_neg    = octant[2] ^ octant[1];

   always_comb begin
      sin_drv = coil_route(sin_on_dac, sin_neg);
      cos_drv = coil_route(~sin_on_dac, cos_neg);
   end

endmodule

// File: rtl/gdd_minor_dec.sv
`timescale 1ns/1ps
module gdd_minor_dec #(
   parameter int DAC_W  = 7,
   parameter int CODE_W = 10
) (
   input  logic [CODE_W-1:0] code,
   output logic              a_dac,
   output logic              b_dac,
   output logic [DAC_W-1:0]  dac,
   output logic              en
);
   localparam int GUARD_W = CODE_W - DAC_W - 1;

   logic half;

   assign half  = code[DAC_W];
   assign dac   = code[DAC_W-1:0] ^ {DAC_W{half}};
   assign a_dac = half;
   assign b_dac = ~half;

   generate
      if (GUARD_W > 0) begin : g_guard
         assign en = ~|code[CODE_W-1:DAC_W+1];
      end else begin : g_no_guard
         assign en = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/gdd_hold_reg.sv
`timescale 1ns/1ps
module gdd_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

endmodule

// File: rtl/gauge_drive_decoder.sv
`timescale 1ns/1ps
module gauge_drive_decoder
   import gdd_pkg::*;
#(
   parameter int N_MINOR    = 2,
   parameter int DAC_W      = 7,
   parameter int MAJ_CODE_W = 10,
   parameter int MIN_CODE_W = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          maj_load,
   input  logic [MAJ_CODE_W-1:0]         maj_word,
   input  logic [N_MINOR-1:0]            min_load,
   input  logic [N_MINOR*MIN_CODE_W-1:0] min_word,
   output logic [1:0]                    sin_p_sel,
   output logic [1:0]                    sin_n_sel,
   output logic [1:0]                    cos_p_sel,
   output logic [1:0]                    cos_n_sel,
   output logic [DAC_W-1:0]              maj_dac,
   output logic [N_MINOR-1:0]            min_a_dac,
   output logic [N_MINOR-1:0]            min_b_dac,
   output logic [N_MINOR*DAC_W-1:0]      min_dac,
   output logic [N_MINOR-1:0]            min_en
);
   localparam int MAJ_W   = 8 + DAC_W;
   localparam int MIN_W   = DAC_W + 3;
   localparam int GUARD_W = MIN_CODE_W - DAC_W - 1;

   if (MAJ_CODE_W != DAC_W + 3) begin : g_bad_major
      $error("MAJ_CODE_W must equal DAC_W + 3");
   end
   if (GUARD_W < 0) begin : g_bad_minor
      $error("MIN_CODE_W must be at least DAC_W + 1");
   end
   if (N_MINOR < 1) begin : g_bad_count
      $error("N_MINOR must be at least 1");
   end

   // ---------------- major channel ----------------
   coil_drv_t        sin_d, cos_d;
   logic [DAC_W-1:0] maj_dac_d;
   logic [MAJ_W-1:0] maj_q;

   gdd_major_dec #(.DAC_W(DAC_W), .CODE_W(MAJ_CODE_W)) u_major_dec (
      .code    (maj_word),
      .sin_drv (sin_d),
      .cos_drv (cos_d),
      .dac     (maj_dac_d)
   );

   gdd_hold_reg #(.W(MAJ_W)) u_major_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (maj_load),
      .d     ({sin_d, cos_d, maj_dac_d}),
      .q     (maj_q)
   );

   assign sin_p_sel = maj_q[MAJ_W-1 -: 2];
   assign sin_n_sel = maj_q[MAJ_W-3 -: 2];
   assign cos_p_sel = maj_q[MAJ_W-5 -: 2];
   assign cos_n_sel = maj_q[MAJ_W-7 -: 2];
   assign maj_dac   = maj_q[DAC_W-1:0];

   assert_one_dac_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sin_p_sel == DRV_DAC, sin_n_sel == DRV_DAC,
                cos_p_sel == DRV_DAC, cos_n_sel == DRV_DAC}));

   assert_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      maj_load |=> (maj_dac == ($past(maj_word[DAC_W-1:0]) ^ {DAC_W{$past(maj_word[DAC_W])}})));

   assert_sin_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sin_p_sel == DRV_HI) |-> (sin_n_sel == DRV_LO));

   // ---------------- minor channels ----------------
   for (genvar g = 0; g < N_MINOR; g++) begin : g_minor
      logic             a_d, b_d, en_d;
      logic [DAC_W-1:0] dac_d;
      logic [MIN_W-1:0] q;

      gdd_minor_dec #(.DAC_W(DAC_W), .CODE_W(MIN_CODE_W)) u_dec (
         .code  (min_word[g*MIN_CODE_W +: MIN_CODE_W]),
         .a_dac (a_d),
         .b_dac (b_d),
         .dac   (dac_d),
         .en    (en_d)
      );

      gdd_hold_reg #(.W(MIN_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (min_load[g]),
         .d     ({a_d, b_d, dac_d, en_d}),
         .q     (q)
      );

      assign min_a_dac[g]                = q[MIN_W-1];
      assign min_b_dac[g]                = q[MIN_W-2];
      assign min_dac[g*DAC_W +: DAC_W]   = q[DAC_W:1];
      assign min_en[g]                   = q[0];

      assert_sides_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !(min_a_dac[g] && min_b_dac[g]));

      if (GUARD_W > 0) begin : g_en_chk
         assert_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
            min_load[g] |=> (min_en[g] == ($past(min_word[g*MIN_CODE_W+DAC_W+1 +: GUARD_W]) == '0)));
      end
   end

endmodule

// File: tb/tb_gauge_drive_decoder.sv
`timescale 1ns/1ps
module tb_gauge_drive_decoder;
   localparam int NM = 2;
   localparam int DW = 7;
   localparam int CW = 10;
   localparam int SW = 8 + DW + NM * (DW + 3);
   localparam logic [1:0] LO = 2'd0, HI = 2'd1, DA = 2'd2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n;
   logic             maj_load;
   logic [CW-1:0]    maj_word;
   logic [NM-1:0]    min_load;
   logic [NM*CW-1:0] min_word;
   logic [1:0]       sin_p_sel, sin_n_sel, cos_p_sel, cos_n_sel;
   logic [DW-1:0]    maj_dac;
   logic [NM-1:0]    min_a_dac, min_b_dac, min_en;
   logic [NM*DW-1:0] min_dac;

   gauge_drive_decoder #(.N_MINOR(NM), .DAC_W(DW), .MAJ_CODE_W(CW), .MIN_CODE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .maj_load(maj_load), .maj_word(maj_word),
      .min_load(min_load), .min_word(min_word),
      .sin_p_sel(sin_p_sel), .sin_n_sel(sin_n_sel), .cos_p_sel(cos_p_sel), .cos_n_sel(cos_n_sel),
      .maj_dac(maj_dac), .min_a_dac(min_a_dac), .min_b_dac(min_b_dac),
      .min_dac(min_dac), .min_en(min_en)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // expected model state
   logic [1:0]       e_sp = LO, e_sn = LO, e_cp = LO, e_cn = LO;
   logic [DW-1:0]    e_dac = '0;
   logic [NM-1:0]    e_a = '0, e_b = '0, e_en = '0;
   logic [NM*DW-1:0] e_mdac = '0;

   typedef struct {
      logic [SW-1:0] snap;
      string         tag;
      int            mono;
   } item_t;
   item_t sb[$];

   function automatic logic [SW-1:0] actual();
      return {sin_p_sel, sin_n_sel, cos_p_sel, cos_n_sel, maj_dac, min_a_dac, min_b_dac, min_dac, min_en};
   endfunction

   function automatic logic [SW-1:0] expected();
      return {e_sp, e_sn, e_cp, e_cn, e_dac, e_a, e_b, e_mdac, e_en};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // octant table written from R4/R5
   task automatic model_major(input logic [CW-1:0] c);
      int oct, low;
      oct = int'(c[9:7]);
      low = int'(c[6:0]);
      case (oct)
         0: begin e_sp = DA; e_sn = LO; e_cp = HI; e_cn = LO; end
         1: begin e_sp = HI; e_sn = LO; e_cp = DA; e_cn = LO; end
         2: begin e_sp = HI; e_sn = LO; e_cp = LO; e_cn = DA; end
         3: begin e_sp = DA; e_sn = LO; e_cp = LO; e_cn = HI; end
         4: begin e_sp = LO; e_sn = DA; e_cp = LO; e_cn = HI; end
         5: begin e_sp = LO; e_sn = HI; e_cp = LO; e_cn = DA; end
         6: begin e_sp = LO; e_sn = HI; e_cp = DA; e_cn = LO; end
         default: begin e_sp = LO; e_sn = DA; e_cp = HI; e_cn = LO; end
      endcase
      e_dac = DW'((oct % 2 == 1) ? 127 - low : low);
   endtask

   task automatic model_minor(input int ch, input logic [CW-1:0] w);
      int low;
      low = int'(w[6:0]);
      e_a[ch] = w[7];
      e_b[ch] = !w[7];
      e_mdac[ch*DW +: DW] = DW'(w[7] ? 127 - low : low);
      e_en[ch] = (w[9:8] == 2'b00);
   endtask

   // driver: present one cycle of stimulus and push the expected snapshot
   task automatic step(input logic ml, input logic [CW-1:0] mw,
                       input logic [NM-1:0] nl, input logic [NM*CW-1:0] nw,
                       input string tag, input int mono);
      item_t it;
      @(negedge clk);
      maj_load = ml; maj_word = mw; min_load = nl; min_word = nw;
      if (ml) model_major(mw);
      for (int ch = 0; ch < NM; ch++)
         if (nl[ch]) model_minor(ch, nw[ch*CW +: CW]);
      it.snap = expected();
      it.tag  = tag;
      it.mono = mono;
      sb.push_back(it);
   endtask

   // monitor: compares one edge after each driven cycle
   logic [DW-1:0] last_dac = '0;
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.tag, 64'(actual()), 64'(it.snap));
            if (it.mono == 1) chk("R11 rising", 64'(maj_dac), 64'(DW'(last_dac + 1'b1)));
            if (it.mono == 2) chk("R11 falling", 64'(maj_dac), 64'(DW'(last_dac - 1'b1)));
            last_dac = maj_dac;
         end
      end
   end

   initial begin
      #(60000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; maj_load = 1'b0; maj_word = 10'h155; min_load = '1; min_word = '1;
      repeat (3) @(negedge clk);
      chk("R1 reset", 64'(actual()), 64'(expected()));
      rst_n = 1'b1;
      min_load = '0;
      @(negedge clk);
      chk("R1 after release", 64'(actual()), 64'(expected()));

      // strobe low: changing words ignored
      step(1'b0, 10'h3A5, '0, 20'hABCDE, "R2 no load", 0);
      step(1'b0, 10'h07F, '0, 20'h12345, "R2 no load", 0);

      // anchor codes
      step(1'b1, 10'd0,   '0, '0, "R6 code 0", 0);
      step(1'b1, 10'd256, '0, '0, "R6 code 256", 0);
      step(1'b1, 10'd512, '0, '0, "R6 code 512", 0);
      step(1'b1, 10'd768, '0, '0, "R6 code 768", 0);

      // full sweep with direction check inside each octant
      for (int c = 0; c < 1024; c++) begin
         int mono;
         if (c % 128 == 0)        mono = 0;
         else if ((c / 128) % 2)  mono = 2;
         else                     mono = 1;
         step(1'b1, CW'(c), '0, '0, "R3 R4 R5 sweep", mono);
      end

      // minor crossover and extremes on channel 0
      step(1'b0, 10'h000, 2'b01, {10'h000, 10'd0},   "R7 R8 minor 0", 0);
      step(1'b0, 10'h000, 2'b01, {10'h000, 10'd127}, "R7 R8 minor 127", 0);
      step(1'b0, 10'h000, 2'b01, {10'h000, 10'd128}, "R7 R8 minor 128", 0);
      step(1'b0, 10'h000, 2'b01, {10'h000, 10'd255}, "R7 R8 minor 255", 0);

      // guard bits on channel 1
      step(1'b0, 10'h000, 2'b10, {10'h105, 10'd0}, "R9 guard 01", 0);
      step(1'b0, 10'h000, 2'b10, {10'h285, 10'd0}, "R9 guard 10", 0);
      step(1'b0, 10'h000, 2'b10, {10'h3C5, 10'd0}, "R9 guard 11", 0);
      step(1'b0, 10'h000, 2'b10, {10'h0C5, 10'd0}, "R9 guard 00", 0);

      // simultaneous major and minor loads, channel 0 word moving without strobe
      step(1'b1, 10'd300, 2'b10, {10'h050, 10'h2FF}, "R10 same-cycle loads", 0);
      step(1'b0, 10'd999, 2'b01, {10'h3FF, 10'h0AA}, "R10 single channel", 0);
      step(1'b1, 10'd901, 2'b11, {10'h07E, 10'h081}, "R10 all channels", 0);
      step(1'b0, 10'd5,   2'b00, {10'h111, 10'h222}, "R2 hold", 0);

      @(negedge clk);
      maj_load = 1'b0; min_load = '0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule